// File: doc/BRIEF.md
# Transmit Byte Mover

The block is a single-channel engine that moves bytes from memory into the data register of a serial transmitter. Software writes three configuration words: the address of the last byte of the message, the address of the transmitter's data register, and a control word with the run mode, the element count minus one and the element-format codes. The engine then waits for the transmitter to report an empty buffer. Each accepted request moves exactly one byte: the engine issues one memory read, then writes the returned byte to the fixed destination.

The source addresses are derived from the end pointer by counting back. Element k of a run with count field C is read from `end - (C - k)`, so the first read sits C bytes below the end pointer and the last read sits on it. After the last element the engine clears its mode field to stopped, raises a one-cycle done pulse and ignores further requests until software writes a new control word.

The controller has four states. **IDLE** samples the request. **READ** drives the memory read strobe. **WRITE** drives the peripheral write strobe and steps the element counter. **DONE** pulses completion and stops the channel. The transitions are: IDLE→READ on an accepted request (channel running, request enable high, buffer empty); READ→WRITE always; WRITE→IDLE when elements remain; WRITE→DONE after the final element; DONE→IDLE always.

Top module: `txdma_engine`

## Requirements
- R1: After reset `mem_rd_en`, `per_wr_en` and `done` are 0 and `active` is 0 (mode stopped).
- R2: A request is accepted only in IDLE, and only while `active`, `req_en` and `tx_empty` are all 1. With `req_en` at 0, no read or write occurs.
- R3: Each accepted request produces one `mem_rd_en` cycle, which begins one cycle after the sampling edge. The next cycle has one `per_wr_en` cycle carrying `mem_rd_data`, which memory returns in the cycle after the read strobe. A one-cycle `tx_empty` pulse moves exactly one byte.
- R4: With end pointer E and count field C, element k (0..C) is read from address E−(C−k). The addresses rise by one per element and end on E.
- R5: Every write goes to `per_wr_addr` equal to the destination word written under `cfg_sel`=1. This address never changes during a run.
- R6: A run moves exactly C+1 bytes.
- R7: After the final write, `done` is high for one cycle and `active` falls. Later requests move nothing until a new control word is written.
- R8: Only mode code 1 (basic) runs the channel. Mode 0 (stopped) and codes 2–7 accept no request.
- R9: Configuration writes arriving while the controller is outside IDLE are ignored. A run continues with its old settings.
- R10: The control word (`cfg_sel`=2) has this layout: mode in [2:0]; count C in [12:3]; arbitration power in [16:13], which must be 0; source size in [18:17], which must be 0 (byte); source increment in [20:19], which must be 0 (+1); destination size in [22:21], which must be 0 (byte); destination increment in [24:23], which must be 3 (fixed); [31:25] must be 0. Any other value stores mode stopped. `cfg_sel`=0 selects the end pointer, `cfg_sel`=1 the destination, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_en | input | 1 | Transmitter request enable |
| tx_empty | input | 1 | Transmitter buffer empty |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after the strobe |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_wr_addr | output | 32 | Peripheral write address |
| per_wr_data | output | 8 | Peripheral write data |
| done | output | 1 | One-cycle completion pulse |
| active | output | 1 | Channel mode is basic |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the single cycle while an element is in flight. The stimulus raises `tx_empty` for one cycle. It then drives a stopping control word on the falling edge that lies inside the READ cycle. After that it checks that the run still finishes with its original address sequence and count. Reaching the end-of-run stop also takes a full run of C+1 paced requests, so the table gives both a single-element run and runs whose count reaches back to address zero.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } dma_state_t;

    localparam logic [2:0] MODE_STOP  = 3'd0;
    localparam logic [2:0] MODE_BASIC = 3'd1;

    localparam logic [1:0] SEL_END  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam logic [1:0] INC_PLUS1 = 2'd0;
    localparam logic [1:0] INC_NONE  = 2'd3;
    localparam logic [1:0] SIZE_BYTE = 2'd0;

endpackage

// File: rtl/txdma_desc.sv
module txdma_desc
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              wr_allow,
    input  logic              stop,
    output logic              ctrl_load,
    output logic [CNT_W-1:0]  ctrl_count,
    output logic [ADDR_W-1:0] end_ptr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [2:0]        mode
);
    localparam int F_CNT  = 3;
    localparam int F_ARB  = F_CNT + CNT_W;
    localparam int F_SSZ  = F_ARB + 4;
    localparam int F_SINC = F_SSZ + 2;
    localparam int F_DSZ  = F_SINC + 2;
    localparam int F_DINC = F_DSZ + 2;
    localparam int F_RSV  = F_DINC + 2;
    localparam int RSV_W  = CFG_W - F_RSV;

    logic format_ok;
    logic wr_end, wr_dst;

    assign wr_end     = cfg_wr && wr_allow && (cfg_sel == SEL_END);
    assign wr_dst     = cfg_wr && wr_allow && (cfg_sel == SEL_DST);
    assign ctrl_load  = cfg_wr && wr_allow && (cfg_sel == SEL_CTRL);
    assign ctrl_count = cfg_wdata[F_CNT +: CNT_W];

    // Only the one element format the engine moves is accepted.
    assign format_ok = (cfg_wdata[F_ARB +: 4]  == 4'd0)
                    && (cfg_wdata[F_SSZ +: 2]  == SIZE_BYTE)
                    && (cfg_wdata[F_SINC +: 2] == INC_PLUS1)
                    && (cfg_wdata[F_DSZ +: 2]  == SIZE_BYTE)
                    && (cfg_wdata[F_DINC +: 2] == INC_NONE)
                    && (cfg_wdata[CFG_W-1:F_RSV] == RSV_W'(0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_ptr  <= '0;
            dst_addr <= '0;
            mode     <= MODE_STOP;
        end else begin
            if (wr_end) end_ptr  <= cfg_wdata[ADDR_W-1:0];
            if (wr_dst) dst_addr <= cfg_wdata[ADDR_W-1:0];
            if (stop)
                mode <= MODE_STOP;
            else if (ctrl_load)
                mode <= format_ok ? cfg_wdata[2:0] : MODE_STOP;
        end
    end

endmodule

// File: rtl/txdma_addr.sv
module txdma_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              step,
    input  logic [ADDR_W-1:0] end_ptr,
    output logic [ADDR_W-1:0] src_addr,
    output logic              last
);
    // Elements still to move after the current one.
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_count;
        else if (step && !last)
            remain <= remain - 1'b1;
    end

    assign last     = (remain == '0);
    assign src_addr = end_ptr - ADDR_W'(remain);

endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
    import txdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic last,
    output logic idle,
    output logic rd_en,
    output logic wr_en,
    output logic step,
    output logic stop,
    output logic done
);
    dma_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        idle    = 1'b0;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        step    = 1'b0;
        stop    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
                if (go) state_d = ST_READ;
            end
            ST_READ: begin
                rd_en   = 1'b1;
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                wr_en   = 1'b1;
                step    = 1'b1;
                state_d = last ? ST_DONE : ST_IDLE;
            end
            ST_DONE: begin
                done    = 1'b1;
                stop    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_en,
    input  logic              tx_empty,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              per_wr_en,
    output logic [ADDR_W-1:0] per_wr_addr,
    output logic [BYTE_W-1:0] per_wr_data,
    output logic              done,
    output logic              active
);
    logic              idle, step, stop, last, go, ctrl_load;
    logic [CNT_W-1:0]  ctrl_count;
    logic [ADDR_W-1:0] end_ptr, dst_addr, src_addr;
    logic [2:0]        mode;

    txdma_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(32)) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .wr_allow   (idle),
        .stop       (stop),
        .ctrl_load  (ctrl_load),
        .ctrl_count (ctrl_count),
        .end_ptr    (end_ptr),
        .dst_addr   (dst_addr),
        .mode       (mode)
    );

    txdma_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctrl_load),
        .load_count (ctrl_count),
        .step       (step),
        .end_ptr    (end_ptr),
        .src_addr   (src_addr),
        .last       (last)
    );

    assign active = (mode == MODE_BASIC);
    assign go     = active && req_en && tx_empty;

    txdma_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .last  (last),
        .idle  (idle),
        .rd_en (mem_rd_en),
        .wr_en (per_wr_en),
        .step  (step),
        .stop  (stop),
        .done  (done)
    );

    assign mem_rd_addr = src_addr;
    assign per_wr_addr = dst_addr;
    assign per_wr_data = mem_rd_data;

endmodule

// File: rtl/txdma_engine_chk.sv
module txdma_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd_en,
    input logic per_wr_en,
    input logic done,
    input logic active
);
    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> per_wr_en);

    a_r3_read_precedes_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_wr_en) |-> $past(mem_rd_en));

    a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, per_wr_en, done}));

    a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_read_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> $past(active));

endmodule

bind txdma_engine txdma_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .per_wr_en (per_wr_en),
    .done      (done),
    .active    (active)
);

// File: tb/txdma_engine_bench.sv
module txdma_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CTRL_FMT = 32'h0180_0000;  // dst increment code 3 at [24:23]

    // Each row: end pointer, count field, expected first source address.
    localparam logic [79:0] VEC [4] = '{
        {32'h0000_1003, 16'd3, 32'h0000_1000},
        {32'h0000_0020, 16'd0, 32'h0000_0020},
        {32'h0000_0105, 16'd7, 32'h0000_00FE},
        {32'h0000_0007, 16'd7, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        req_en = 1'b0;
    logic        tx_empty = 1'b0;
    logic        mem_rd_en, per_wr_en, done, active;
    logic [31:0] mem_rd_addr, per_wr_addr;
    logic [7:0]  mem_rd_data = 8'd0;
    logic [7:0]  per_wr_data;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int done_cnt = 0;
    logic [31:0] last_wr_addr, last_rd_addr;
    logic [7:0]  last_wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdma_engine u_txdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_en(req_en), .tx_empty(tx_empty),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
        .done(done), .active(active)
    );

    function automatic logic [7:0] mem_val(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (per_wr_en) begin
            wr_cnt <= wr_cnt + 1;
            last_wr_addr <= per_wr_addr;
            last_wr_data <= per_wr_data;
        end
        if (mem_rd_en) begin
            rd_cnt <= rd_cnt + 1;
            last_rd_addr <= mem_rd_addr;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic setup(input logic [31:0] e, input logic [31:0] d, input logic [31:0] ctrl);
        cfg_write(2'd0, e);
        cfg_write(2'd1, d);
        cfg_write(2'd2, ctrl);
    endtask

    // One-cycle empty pulse, then wait past the write and done cycles.
    task automatic pulse_empty();
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk); tx_empty = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_en", 32'(mem_rd_en), 0);
        check("R1 wr_en", 32'(per_wr_en), 0);
        check("R1 done",  32'(done), 0);
        check("R1 active", 32'(active), 0);
        rst_n = 1'b1;
        req_en = 1'b1;
        @(negedge clk);

        // Table walk: R4, R5, R6, R7
        foreach (VEC[i]) begin
            logic [31:0] e, first, dst;
            logic [15:0] c;
            {e, c, first} = VEC[i];
            dst = 32'h4000_0010 + 32'(i);
            setup(e, dst, CTRL_FMT | (32'(c) << 3) | 32'd1);
            check("R10 accepted", 32'(active), 1);
            base = wr_cnt;
            for (int k = 0; k <= int'(c); k++) begin
                pulse_empty();
                check("R3 one byte per pulse", 32'(wr_cnt - base), 32'(k + 1));
                check("R4 source address", last_rd_addr, first + 32'(k));
                check("R3 data", 32'(last_wr_data), 32'(mem_val(first + 32'(k))));
                check("R5 destination", last_wr_addr, dst);
            end
            check("R4 last equals end", last_rd_addr, e);
            check("R6 count", 32'(wr_cnt - base), 32'(c) + 1);
            check("R7 done pulses", 32'(done_cnt), 32'(i + 1));
            check("R7 inactive", 32'(active), 0);
            pulse_empty();
            check("R7 ignored after done", 32'(wr_cnt - base), 32'(c) + 1);
        end

        // R2: request enable low blocks transfer
        setup(32'h200, 32'h4000_0000, CTRL_FMT | (32'd1 << 3) | 32'd1);
        req_en = 1'b0;
        base = wr_cnt;
        pulse_empty();
        check("R2 req_en low", 32'(wr_cnt - base), 0);
        req_en = 1'b1;

        // R8: other mode codes do not run
        setup(32'h200, 32'h4000_0000, CTRL_FMT | (32'd1 << 3) | 32'd2);
        base = wr_cnt;
        pulse_empty();
        check("R8 mode 2", 32'(wr_cnt - base), 0);
        setup(32'h200, 32'h4000_0000, CTRL_FMT | (32'd1 << 3) | 32'd0);
        pulse_empty();
        check("R8 mode 0", 32'(wr_cnt - base), 0);

        // R10: wrong destination increment code stops the channel
        setup(32'h200, 32'h4000_0000, (32'd1 << 3) | 32'd1);
        check("R10 bad format", 32'(active), 0);
        pulse_empty();
        check("R10 no transfer", 32'(wr_cnt - base), 0);

        // R9: config write inside READ cycle is ignored
        setup(32'h300, 32'h4000_0020, CTRL_FMT | (32'd2 << 3) | 32'd1);
        base = wr_cnt;
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk); tx_empty = 1'b0;
        cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'd0;
        @(negedge clk); cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 still active", 32'(active), 1);
        check("R9 first address", last_rd_addr, 32'h2FE);
        pulse_empty();
        pulse_empty();
        check("R9 run completes", 32'(wr_cnt - base), 3);
        check("R9 last address", last_rd_addr, 32'h300);

        // R3: held-empty for one cycle on idle gives exactly one move
        setup(32'h400, 32'h4000_0030, CTRL_FMT | (32'd5 << 3) | 32'd1);
        base = rd_cnt;
        pulse_empty();
        check("R3 single read", 32'(rd_cnt - base), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule